// File: doc/BRIEF.md
# Receive Character Retiming Buffer

This block sits between the sliced output of a 1200 baud FSK receiver and a small host controller that has no UART. It watches the demodulated serial stream for the falling edge that opens an asynchronous character. It times out to the centre of each following bit and collects the nine bits that come after the start bit. The finished character is copied in one step into a holding register.

If the host is holding its strobe line low when that copy happens, the block pulls its active-low ready flag low and presents the first captured bit on the serial output. The host then pulls the character out one bit at a time with software-timed strobe pulses. If the strobe is high at the copy, no handshake starts and the serial output simply follows the demodulated stream.

The enable input comes from the mode decoder. It is high only in the receive modes that run at 1200 baud. While the enable is low, the serial output is held low and no character is captured or offered.

Top module: `rx_char_retimer`

## Requirements
- R1: Right after reset, `rdy_n` is 1 and `rxd` is 0.
- R2: A character that completes while the synchronised strobe is high leaves `rdy_n` at 1. Outside a handshake, `rxd` equals `rx_raw` delayed by three clock cycles (two synchroniser stages plus the output register).
- R3: A high-to-low transition on the synchronised `rx_raw` marks a start bit. The nine bits that follow are sampled one and a half bit periods after that edge and then every `CLKS_PER_BIT` cycles. The first bit received is the first bit presented.
- R4: A character that completes while the synchronised strobe is low drives `rdy_n` to 0, and `rxd` then shows the first received bit.
- R5: During a handshake, the first rising edge of the strobe returns `rdy_n` to 1.
- R6: During a handshake, each of the first eight falling edges of the strobe advances `rxd` to the next received bit, giving bits two to nine in order.
- R7: The ninth falling edge of the strobe ends the handshake, and `rxd` returns to the raw stream.
- R8: While `rx_on` is 0, `rxd` is 0 and `rdy_n` is 1, and any capture in progress is dropped.
- R9: A character that completes during an unfinished handshake replaces the held bits, restarts the pulse count and re-samples the strobe level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_on | input | 1 | High in the 1200 baud receive modes |
| rx_raw | input | 1 | Demodulated serial data, asynchronous |
| host_strobe | input | 1 | Host strobe line, asynchronous |
| rxd | output | 1 | Serial output to the host, either retimed bits or raw data |
| rdy_n | output | 1 | Active-low character-ready flag |

## Verification
The hardest case to reach is a second character finishing while the host is only part way through unloading the first one. That needs a fully timed character to arrive while the held word is partly shifted and the pulse count is in the middle of its range. The bench gets there by starting a normal handshake, stopping after three strobe pulses, and sending a second character with the strobe held low. It then checks that the ready flag drops again and that all nine bits of the new character come out from its first bit onward. Passthrough is checked by sampling `rxd` in the middle of every bit while the strobe is held high.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [0:0] {
    CAP_HUNT = 1'b0,
    CAP_BITS = 1'b1
  } cap_state_t;
endpackage

// File: rtl/rtr_sync.sv
module rtr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rtr_capture.sv
module rtr_capture
  import rtr_pkg::*;
#(
  parameter int WORD_W       = 9,
  parameter int CLKS_PER_BIT = 2983
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              line,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int FIRST_WAIT = CLKS_PER_BIT + CLKS_PER_BIT / 2;
  localparam int TW         = $clog2(FIRST_WAIT + 1);
  localparam int CW         = $clog2(WORD_W + 1);

  cap_state_t    state;
  logic [TW-1:0] timer;
  logic [CW-1:0] nbits;
  logic          line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= CAP_HUNT;
      timer  <= '0;
      nbits  <= '0;
      line_q <= 1'b1;
      done   <= 1'b0;
      word   <= '0;
    end else begin
      line_q <= line;
      done   <= 1'b0;
      if (!enable) begin
        state <= CAP_HUNT;
        nbits <= '0;
      end else begin
        case (state)
          CAP_HUNT: begin
            if (line_q && !line) begin
              state <= CAP_BITS;
              timer <= TW'(FIRST_WAIT - 2);
              nbits <= '0;
            end
          end
          CAP_BITS: begin
            if (timer == '0) begin
              word  <= {line, word[WORD_W-1:1]};
              timer <= TW'(CLKS_PER_BIT - 1);
              if (nbits == CW'(WORD_W - 1)) begin
                done  <= 1'b1;
                nbits <= '0;
                state <= CAP_HUNT;
              end else begin
                nbits <= nbits + 1'b1;
              end
            end else begin
              timer <= timer - 1'b1;
            end
          end
          default: state <= CAP_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtr_handover.sv
module rtr_handover #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              raw,
  input  logic              strobe,
  input  logic              strb_rise,
  input  logic              strb_fall,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              rxd_o,
  output logic              rdy_n_o
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] hold;
  logic [CW-1:0]     falls;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      falls   <= '0;
      active  <= 1'b0;
      rdy_n_o <= 1'b1;
      rxd_o   <= 1'b0;
    end else begin
      rxd_o <= enable & (active ? hold[0] : raw);
      if (!enable) begin
        active  <= 1'b0;
        rdy_n_o <= 1'b1;
        falls   <= '0;
      end else if (load) begin
        hold    <= word;
        falls   <= '0;
        active  <= ~strobe;
        rdy_n_o <= strobe;
      end else if (active) begin
        if (strb_rise) rdy_n_o <= 1'b1;
        if (strb_fall) begin
          if (falls == CW'(WORD_W - 1)) begin
            active <= 1'b0;
            falls  <= '0;
          end else begin
            hold  <= {1'b0, hold[WORD_W-1:1]};
            falls <= falls + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rx_char_retimer.sv
module rx_char_retimer #(
  parameter int WORD_W       = 9,
  parameter int CLKS_PER_BIT = 2983,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_on,
  input  logic rx_raw,
  input  logic host_strobe,
  output logic rxd,
  output logic rdy_n
);
  logic              raw_s;
  logic              strb_s;
  logic              strb_q;
  logic              strb_rise;
  logic              strb_fall;
  logic              char_done;
  logic [WORD_W-1:0] char_word;

  rtr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_raw (
    .clk(clk), .rst(rst), .d(rx_raw), .q(raw_s)
  );

  rtr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_strb (
    .clk(clk), .rst(rst), .d(host_strobe), .q(strb_s)
  );

  always_ff @(posedge clk) begin
    if (rst) strb_q <= 1'b0;
    else     strb_q <= strb_s;
  end

  assign strb_rise = strb_s & ~strb_q;
  assign strb_fall = ~strb_s & strb_q;

  rtr_capture #(.WORD_W(WORD_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_capture (
    .clk(clk), .rst(rst), .enable(rx_on), .line(raw_s),
    .done(char_done), .word(char_word)
  );

  rtr_handover #(.WORD_W(WORD_W)) u_handover (
    .clk(clk), .rst(rst), .enable(rx_on), .raw(raw_s),
    .strobe(strb_s), .strb_rise(strb_rise), .strb_fall(strb_fall),
    .load(char_done), .word(char_word),
    .rxd_o(rxd), .rdy_n_o(rdy_n)
  );
endmodule

// File: rtl/rtr_checker.sv
module rtr_checker (
  input logic clk,
  input logic rst,
  input logic rx_on,
  input logic rxd,
  input logic rdy_n,
  input logic char_done,
  input logic strb_rise
);
  assert_rxd_low_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_on |=> !rxd);

  assert_ready_idle_when_off_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_on |=> rdy_n);

  assert_ready_only_after_char_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> $past(char_done));

  assert_rise_releases_ready_R5: assert property (@(posedge clk) disable iff (rst)
    (rx_on && strb_rise && !char_done && !rdy_n) |=> rdy_n);

  assert_done_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    char_done |=> !char_done);
endmodule

bind rx_char_retimer rtr_checker u_rtr_checker (
  .clk(clk), .rst(rst), .rx_on(rx_on), .rxd(rxd), .rdy_n(rdy_n),
  .char_done(char_done), .strb_rise(strb_rise)
);

// File: tb/rx_char_retimer_bench.sv
module rx_char_retimer_bench;
  localparam int BIT = 16;
  localparam int W   = 9;
  localparam int NV  = 6;
  // {strobe held high (passthrough), nine data bits, first received in bit 0}
  localparam logic [9:0] VEC [NV] = '{
    10'h155, 10'h0AA, 10'h000, 10'h1FF, 10'h2F0, 10'h1C3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_on = 1'b0;
  logic rx_raw = 1'b1;
  logic host_strobe = 1'b0;
  logic rxd;
  logic rdy_n;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;

  always #10 clk = ~clk;

  rx_char_retimer #(.WORD_W(W), .CLKS_PER_BIT(BIT)) u_rx_char_retimer (
    .clk(clk), .rst(rst), .rx_on(rx_on), .rx_raw(rx_raw),
    .host_strobe(host_strobe), .rxd(rxd), .rdy_n(rdy_n)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send(input logic [8:0] d, input bit watch);
    rx_raw = 1'b0;
    tick(BIT);
    for (int i = 0; i < W; i++) begin
      rx_raw = d[i];
      tick(BIT / 2);
      if (watch) chk("R2 passthrough bit", rxd, d[i]);
      tick(BIT - BIT / 2);
    end
    rx_raw = 1'b1;
    tick(2 * BIT);
  endtask

  task automatic unload(input logic [8:0] d, input int pulses);
    for (int k = 0; k < pulses; k++) begin
      host_strobe = 1'b1;
      tick(6);
      if (k == 0) chk("R5 ready released", rdy_n, 1'b1);
      host_strobe = 1'b0;
      tick(6);
      if (k < W - 1) chk("R6 shifted bit", rxd, d[k + 1]);
      else begin
        chk("R7 back to raw", rxd, rx_raw);
        chk("R7 ready idle", rdy_n, 1'b1);
      end
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R3 actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1 reset rdy_n", rdy_n, 1'b1);
    chk("R1 reset rxd", rxd, 1'b0);
    rst = 1'b0;
    rx_on = 1'b1;
    tick(6);
    chk("R2 idle line passthrough", rxd, 1'b1);

    for (int v = 0; v < NV; v++) begin
      host_strobe = VEC[v][9];
      tick(6);
      send(VEC[v][8:0], VEC[v][9]);
      if (VEC[v][9]) begin
        chk("R2 no ready with strobe high", rdy_n, 1'b1);
        chk("R2 raw after char", rxd, 1'b1);
        host_strobe = 1'b0;
        tick(6);
      end else begin
        chk("R4 ready asserted", rdy_n, 1'b0);
        chk("R3 R4 first bit shown", rxd, VEC[v][0]);
        unload(VEC[v][8:0], W);
      end
    end

    // R9: second character arrives mid-unload
    send(9'h0B5, 1'b0);
    chk("R4 ready before overwrite", rdy_n, 1'b0);
    unload(9'h0B5, 3);
    send(9'h14A, 1'b0);
    chk("R9 ready after overwrite", rdy_n, 1'b0);
    chk("R9 new first bit", rxd, 1'b0);
    unload(9'h14A, W);

    // R8: receiver disabled
    rx_on = 1'b0;
    tick(3);
    chk("R8 rxd low when off", rxd, 1'b0);
    chk("R8 rdy_n high when off", rdy_n, 1'b1);
    send(9'h0F0, 1'b0);
    chk("R8 no ready when off", rdy_n, 1'b1);
    chk("R8 rxd still low", rxd, 1'b0);
    rx_on = 1'b1;
    tick(6);
    chk("R8 raw after re-enable", rxd, 1'b1);
    chk("R8 no stale ready", rdy_n, 1'b1);

    summary();
    $finish;
  end
endmodule